// File: doc/BRIEF.md
# Signed Array Bounds Checker

The block tests one index against a window of two signed limits. The lower limit is inclusive and the upper limit is exclusive, so the allowed range is lower <= index < upper. A request may use a 16-bit operand size or a 32-bit operand size, selected one request at a time. One clock after a request, the block returns a one-cycle result strobe and a flag that marks an out-of-range index. The flag then keeps that value until the next result.

Both operand sizes share a single pair of 32-bit signed comparators. In 16-bit mode, each operand is reduced to its low half and sign-extended to the full width before it reaches the comparators. The bits above bit 15 therefore have no effect in that mode. The flag only reports a violation. Acting on it is left to the surrounding logic.

Top module: `bnd_check`

## Requirements
- R1: While rst_ni is low, rsp_valid_o and oob_o are 0, and both stay 0 after reset until the first request is taken.
- R2: rsp_valid_o is 1 in the cycle after each cycle in which req_valid_i is 1, and is 0 in the cycle after each cycle in which req_valid_i is 0.
- R3: A request whose index is signed-less than the lower limit gives oob_o = 1.
- R4: A request whose index is signed-greater than or equal to the upper limit gives oob_o = 1, so an index equal to the upper limit is out of range.
- R5: A request with lower <= index < upper (signed) gives oob_o = 0, and this includes an index equal to the lower limit.
- R6: With mode_wide_i = 0, only bits 15:0 of index_i, lo_lim_i and hi_lim_i are used, each taken as a signed 16-bit value. Bits 31:16 have no effect on oob_o.
- R7: With mode_wide_i = 1, all 32 bits of each operand are compared as signed two's-complement values, including the extremes 0x80000000 and 0x7FFFFFFF.
- R8: In a cycle after one with no request, oob_o keeps the value it had before, whatever the data inputs do.
- R9: When the lower limit is signed-greater than or equal to the upper limit, every index gives oob_o = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe; operands are taken in this cycle |
| mode_wide_i | input | 1 | 1: 32-bit operands, 0: 16-bit operands (bits 15:0) |
| index_i | input | 32 | Index to check |
| lo_lim_i | input | 32 | Lower limit, inclusive |
| hi_lim_i | input | 32 | Upper limit, exclusive |
| rsp_valid_o | output | 1 | One-cycle result strobe |
| oob_o | output | 1 | 1 when the last checked index was out of range |

## Verification
The assertions check the following on every cycle: the strobe follows the request by one cycle, the flag holds when there is no request, and several violation cases force the flag high. These cases are an index below the lower limit at 32 bits, an index equal to the upper limit in either mode, and an empty window. Three things show up only in the bench's sweeps: the in-range side of the window, the fact that the upper half-word is ignored in 16-bit mode, and the way the sign bits behave at the 32-bit extremes. Those sweeps cover many pairs of limits and every index near each edge, and the bench computes each expected flag by arithmetic. Clearing on a reset applied in the middle of a run is also checked only by the bench.

// File: rtl/bnd_pkg.sv
package bnd_pkg;
  localparam int unsigned WIDE_W_DEF   = 32;
  localparam int unsigned NARROW_W_DEF = 16;
  localparam int unsigned N_OPS        = 3;

  typedef enum logic {
    MODE_NARROW = 1'b0,
    MODE_WIDE   = 1'b1
  } bnd_mode_e;

  // operand slots in the extension array
  localparam int unsigned OP_IDX = 0;
  localparam int unsigned OP_LO  = 1;
  localparam int unsigned OP_HI  = 2;
endpackage

// File: rtl/bnd_sext.sv
module bnd_sext #(
  parameter int unsigned WIDE_W   = 32,
  parameter int unsigned NARROW_W = 16
) (
  input  bnd_pkg::bnd_mode_e mode_i,
  input  logic [WIDE_W-1:0]  val_i,
  output logic [WIDE_W-1:0]  val_o
);
  localparam int unsigned EXT_W = WIDE_W - NARROW_W;

  generate
    if (EXT_W == 0) begin : g_same
      assign val_o = val_i;
    end else begin : g_ext
      logic [WIDE_W-1:0] narrow_ext;
      assign narrow_ext = {{EXT_W{val_i[NARROW_W-1]}}, val_i[NARROW_W-1:0]};
      assign val_o = (mode_i == bnd_pkg::MODE_WIDE) ? val_i : narrow_ext;
    end
  endgenerate
endmodule

// File: rtl/bnd_cmp.sv
module bnd_cmp #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] idx_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  output logic         below_o,
  output logic         above_o
);
  assign below_o = $signed(idx_i) <  $signed(lo_i);
  assign above_o = $signed(idx_i) >= $signed(hi_i);
endmodule

// File: rtl/bnd_check.sv
module bnd_check
  import bnd_pkg::*;
#(
  parameter int unsigned WIDE_W   = WIDE_W_DEF,
  parameter int unsigned NARROW_W = NARROW_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              mode_wide_i,
  input  logic [WIDE_W-1:0] index_i,
  input  logic [WIDE_W-1:0] lo_lim_i,
  input  logic [WIDE_W-1:0] hi_lim_i,
  output logic              rsp_valid_o,
  output logic              oob_o
);
  bnd_mode_e         mode;
  logic [WIDE_W-1:0] op_raw [N_OPS];
  logic [WIDE_W-1:0] op_ext [N_OPS];
  logic              below, above, viol;

  assign mode           = mode_wide_i ? MODE_WIDE : MODE_NARROW;
  assign op_raw[OP_IDX] = index_i;
  assign op_raw[OP_LO]  = lo_lim_i;
  assign op_raw[OP_HI]  = hi_lim_i;

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    bnd_sext #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_sext (
      .mode_i (mode),
      .val_i  (op_raw[g]),
      .val_o  (op_ext[g])
    );
  end

  bnd_cmp #(.W(WIDE_W)) u_cmp (
    .idx_i   (op_ext[OP_IDX]),
    .lo_i    (op_ext[OP_LO]),
    .hi_i    (op_ext[OP_HI]),
    .below_o (below),
    .above_o (above)
  );

  assign viol = below | above;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      oob_o       <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) oob_o <= viol;
    end
  end

  p_rsp_follows_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  p_no_rsp_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  p_flag_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> $stable(oob_o));
  p_below_lo_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && mode_wide_i && ($signed(index_i) < $signed(lo_lim_i))) |=> oob_o);
  p_eq_hi_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && mode_wide_i && (index_i == hi_lim_i)) |=> oob_o);
  p_narrow_eq_hi_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !mode_wide_i && (index_i[NARROW_W-1:0] == hi_lim_i[NARROW_W-1:0])) |=> oob_o);
  p_empty_window_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && mode_wide_i && ($signed(lo_lim_i) >= $signed(hi_lim_i))) |=> oob_o);
endmodule

// File: tb/bnd_check_tb_top.sv
module bnd_check_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        mode_wide_i = 1'b0;
  logic [31:0] index_i = '0, lo_lim_i = '0, hi_lim_i = '0;
  logic        rsp_valid_o, oob_o;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk_i = ~clk_i;

  bnd_check dut_i (
    .clk_i, .rst_ni, .req_valid_i, .mode_wide_i,
    .index_i, .lo_lim_i, .hi_lim_i, .rsp_valid_o, .oob_o
  );

  function automatic bit exp_oob(bit wide, logic [31:0] i, logic [31:0] l, logic [31:0] h);
    longint si, sl, sh;
    if (wide) begin
      si = $signed(i); sl = $signed(l); sh = $signed(h);
    end else begin
      si = $signed(i[15:0]); sl = $signed(l[15:0]); sh = $signed(h[15:0]);
    end
    return (si < sl) || (si >= sh);
  endfunction

  task automatic chk(bit got, bit exp, string req);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  task automatic run(bit wide, logic [31:0] i, logic [31:0] l, logic [31:0] h, string req);
    @(negedge clk_i);
    req_valid_i = 1'b1; mode_wide_i = wide;
    index_i = i; lo_lim_i = l; hi_lim_i = h;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(rsp_valid_o, 1'b1, "R2 strobe");
    chk(oob_o, exp_oob(wide, i, l, h), req);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    int lims [6] = '{-32768, -5, 0, 3, 100, 32767};
    repeat (3) @(negedge clk_i);
    chk(rsp_valid_o, 1'b0, "R1 strobe in reset");
    chk(oob_o, 1'b0, "R1 flag in reset");
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(rsp_valid_o, 1'b0, "R1 strobe after reset");
    chk(oob_o, 1'b0, "R1 flag after reset");

    // R3 R4 R5 R9 R6: narrow sweep, garbage in upper half-word
    foreach (lims[a]) foreach (lims[b]) begin
      for (int d = -3; d <= 3; d++) begin
        int lo_v = lims[a], hi_v = lims[b];
        logic [15:0] i1 = 16'(lo_v + d), i2 = 16'(hi_v + d);
        string tag = (lo_v >= hi_v) ? "R9 empty narrow" : "R3/R4/R5 narrow";
        run(1'b0, {16'($urandom), i1}, {16'($urandom), 16'(lo_v)}, {16'($urandom), 16'(hi_v)}, tag);
        run(1'b0, {16'($urandom), i2}, {16'($urandom), 16'(lo_v)}, {16'($urandom), 16'(hi_v)}, "R6 upper bits ignored");
      end
    end

    // R7: wide extremes and R6 contrast
    run(1'b1, 32'h8000_0000, 32'h8000_0000, 32'h7FFF_FFFF, "R7 min index in range");
    run(1'b1, 32'h7FFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF, "R7 max index equals hi");
    run(1'b1, 32'h7FFF_FFFE, 32'h8000_0000, 32'h7FFF_FFFF, "R7 below max hi");
    run(1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0001_0000, "R3 wide minus one");
    run(1'b1, 32'h0000_FFFF, 32'h0000_0000, 32'h0001_0000, "R5 wide no sext");
    run(1'b0, 32'h0000_FFFF, 32'h0000_0000, 32'h0001_0000, "R6 narrow sext");
    run(1'b1, 32'h0001_0000, 32'h0001_0000, 32'h0001_0001, "R5 index equals lo");
    run(1'b1, 32'h0001_0000, 32'h0001_0000, 32'h0001_0000, "R9 empty wide");
    for (int k = -2; k <= 2; k++)
      run(1'b1, 32'(-70000 + k), 32'(-70000), 32'(70000), "R3/R5 wide lower edge");

    // R8: flag holds while idle with changing inputs
    run(1'b1, 32'd5, 32'd10, 32'd20, "R3 setup");
    for (int c = 0; c < 3; c++) begin
      mode_wide_i = 1'b1; index_i = 32'd15; lo_lim_i = 32'd10; hi_lim_i = 32'd20;
      @(negedge clk_i);
      chk(oob_o, 1'b1, "R8 hold");
      chk(rsp_valid_o, 1'b0, "R2 idle strobe");
    end

    // R1: reset mid-run clears the flag
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(oob_o, 1'b0, "R1 mid-run reset flag");
    chk(rsp_valid_o, 1'b0, "R1 mid-run reset strobe");
    rst_ni = 1'b1;
    @(negedge clk_i);
    finish_up();
  end
endmodule